// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block picks which interrupt a small 8-bit CPU core takes next. It accepts three kinds of source. The first is a set of external lines, each fed by a group of pins. The second is a set of peripheral flags. The third is three non-maskable sources: the block reset, a dedicated top-level pin and a software trap strobe. Each maskable source has an enable bit and a 2-bit software level. Requests are held in pending latches until they are taken or cleared.

The choice is made in two stages. The highest software level among the eligible maskable requests wins first. If several requests share that level, the fixed hardware order picks one. A maskable request is eligible only when it is enabled and its level is strictly above the running level. The non-maskable sources rank above every maskable source and are accepted at any running level. They raise the running level to 3.

When a request is taken, the block pulses `take` for one cycle. In the same cycle it presents the vector index and the new running level. The core can load the running level again through `lvl_load`, for example when it returns from a routine. A `wake` output tells the core to leave its halt state.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high, `take` is 0 and `run_lvl` is 3. On the first clock edge after `rst` falls, the block takes vector 0 (reset) with `run_lvl` 3.
- R2: Among eligible maskable requests, the one with the highest software level wins. Level 3 is the highest.
- R3: Among eligible requests that share the top level, the lowest source index wins. Sources are numbered external lines first, then peripherals. Source i uses vector index 3+i.
- R4: A maskable request is taken only if its enable bit is 1 and its level is strictly greater than `run_lvl`. If not, it stays pending. It is taken later, once the enable or the running level allows it.
- R5: The non-maskable sources are accepted at any `run_lvl`. Their order is reset (vector 0), then top-level pin (vector 1), then trap (vector 2). Taking one sets `run_lvl` to 3. A top-level pin event is taken even while the trap runs at level 3.
- R6: The top-level pin requests on a rising edge only. Holding the pin high gives exactly one take.
- R7: Each external line is the NAND of its group's pins. A rising edge of that line sets the pending latch. The latch clears when the line is taken, so each edge gives exactly one take.
- R8: A peripheral pending latch is set while its flag is 1. It stays set until its `per_clr` bit is pulsed, and taking it does not clear it. A clear pulse given before service discards the request.
- R9: `take` rises on the clock edge after the pending latch is set. It lasts one cycle per acceptance. `vec_idx` and `run_lvl` show the winner's values in that same cycle.
- R10: `lvl_load` writes `lvl_new` into `run_lvl` on the next edge, unless a take happens on that edge. In that case the take's level wins.
- R11: `wake` is 1 while any non-maskable or external pending latch is set. This holds even when the external line is disabled or masked by the running level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the reset interrupt source |
| tli_pin | input | 1 | Top-level non-maskable pin, rising-edge sensitive |
| trap_req | input | 1 | One-cycle software trap strobe |
| ext_pins | input | N_EXT*GRP_W | External pins, GRP_W per line |
| per_flag | input | N_PER | Peripheral status flags |
| per_clr | input | N_PER | Peripheral clear-sequence strobes |
| src_en | input | N_EXT+N_PER | Enable bit per maskable source |
| src_lvl | input | 2*(N_EXT+N_PER) | 2-bit software level per maskable source |
| lvl_load | input | 1 | Load `lvl_new` into the running level |
| lvl_new | input | 2 | Level to load |
| take | output | 1 | Take-interrupt strobe |
| vec_idx | output | clog2(N_EXT+N_PER+3) | Vector index of the taken source |
| run_lvl | output | 2 | Current running level |
| wake | output | 1 | Wake-up request for the halted core |

## Verification
Several rules are checked by the assertions on every cycle:
- the reset vector follows the release of reset;
- a maskable take always raises the running level;
- a non-maskable take always leaves level 3;
- no take appears without a pending latch;
- a level load lands unless a take overrides it;
- a line edge always sets its latch.

Other behaviours need the directed scenarios, because they depend on the order of events across many cycles:
- which request wins among several with mixed levels;
- ties inside a level;
- requests held back and released by a later level load;
- trap preemption and the single take from a held pin;
- NAND grouping;
- a peripheral request lost to its clear sequence;
- wake-up for a disabled line.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP   = 2'd3;
  localparam int   NMI_CNT   = 3;
  localparam int   VEC_RESET = 0;
  localparam int   VEC_TLI   = 1;
  localparam int   VEC_TRAP  = 2;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int LINES      = 2,
  parameter int GRP_W      = 2,
  parameter bit GROUP_NAND = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LINES*GRP_W-1:0] pins,
  input  logic [LINES-1:0]       clr,
  output logic [LINES-1:0]       pend
);
  logic [LINES-1:0] line, prev, rise;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    if (GROUP_NAND) begin : g_nand
      assign line[g] = ~&pins[g*GRP_W +: GRP_W];
    end else begin : g_plain
      assign line[g] = |pins[g*GRP_W +: GRP_W];
    end
    assign rise[g] = line[g] & ~prev[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[g] <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        prev[g] <= line[g];
        if (rise[g])      pend[g] <= 1'b1;
        else if (clr[g])  pend[g] <= 1'b0;
      end
    end

    // R6 R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (line[g] && !prev[g]) |=> pend[g]);
  end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
  import irq_arb_pkg::*;
#(
  parameter int N  = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   pend,
  input  logic [N-1:0]   en,
  input  logic [2*N-1:0] lvl,
  input  lvl_t           cur_lvl,
  output logic           hit,
  output logic [IW-1:0]  win_idx,
  output lvl_t           win_lvl
);
  logic [N-1:0] elig;
  logic [3:0]   has_lvl;

  for (genvar i = 0; i < N; i++) begin : g_elig
    assign elig[i] = pend[i] & en[i] & (lvl[2*i +: 2] > cur_lvl);
  end

  always_comb begin
    has_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) has_lvl[lvl[2*i +: 2]] = 1'b1;
    end
  end

  always_comb begin
    if (has_lvl[3])      win_lvl = 2'd3;
    else if (has_lvl[2]) win_lvl = 2'd2;
    else                 win_lvl = 2'd1;
  end

  assign hit = |elig;

  always_comb begin
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && lvl[2*i +: 2] == win_lvl) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_EXT = 2,
  parameter int GRP_W = 2,
  parameter int N_PER = 4,
  localparam int N_SRC = N_EXT + N_PER,
  localparam int N_VEC = N_SRC + NMI_CNT,
  localparam int VW    = $clog2(N_VEC),
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tli_pin,
  input  logic                   trap_req,
  input  logic [N_EXT*GRP_W-1:0] ext_pins,
  input  logic [N_PER-1:0]       per_flag,
  input  logic [N_PER-1:0]       per_clr,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [2*N_SRC-1:0]     src_lvl,
  input  logic                   lvl_load,
  input  logic [1:0]             lvl_new,
  output logic                   take,
  output logic [VW-1:0]          vec_idx,
  output logic [1:0]             run_lvl,
  output logic                   wake
);
  logic             reset_pend, trap_pend, tli_pend;
  logic [N_EXT-1:0] ext_pend, ext_clr;
  logic [N_PER-1:0] per_pend;
  logic             m_hit;
  logic [IW-1:0]    m_idx;
  lvl_t             m_lvl;
  logic             grant, tli_clr, trap_clr, reset_clr, m_grant;
  logic [VW-1:0]    sel_vec;
  lvl_t             sel_lvl;

  irq_edge_cap #(.LINES(1), .GRP_W(1), .GROUP_NAND(1'b0)) u_tli (
    .clk(clk), .rst(rst), .pins(tli_pin), .clr(tli_clr), .pend(tli_pend));

  irq_edge_cap #(.LINES(N_EXT), .GRP_W(GRP_W), .GROUP_NAND(1'b1)) u_ext (
    .clk(clk), .rst(rst), .pins(ext_pins), .clr(ext_clr), .pend(ext_pend));

  irq_level_sel #(.N(N_SRC), .IW(IW)) u_sel (
    .pend({per_pend, ext_pend}), .en(src_en), .lvl(src_lvl),
    .cur_lvl(run_lvl), .hit(m_hit), .win_idx(m_idx), .win_lvl(m_lvl));

  always_comb begin
    reset_clr = 1'b0;
    tli_clr   = 1'b0;
    trap_clr  = 1'b0;
    m_grant   = 1'b0;
    sel_lvl   = LVL_TOP;
    sel_vec   = '0;
    if (reset_pend) begin
      reset_clr = 1'b1;
      sel_vec   = VW'(VEC_RESET);
    end else if (tli_pend) begin
      tli_clr   = 1'b1;
      sel_vec   = VW'(VEC_TLI);
    end else if (trap_pend) begin
      trap_clr  = 1'b1;
      sel_vec   = VW'(VEC_TRAP);
    end else if (m_hit) begin
      m_grant   = 1'b1;
      sel_lvl   = m_lvl;
      sel_vec   = VW'(NMI_CNT) + VW'(m_idx);
    end
  end

  assign grant = reset_clr | tli_clr | trap_clr | m_grant;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext_clr
    assign ext_clr[i] = m_grant && (m_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_pend <= 1'b1;
      trap_pend  <= 1'b0;
      per_pend   <= '0;
      take       <= 1'b0;
      vec_idx    <= '0;
      run_lvl    <= LVL_TOP;
    end else begin
      reset_pend <= reset_pend & ~reset_clr;
      trap_pend  <= trap_req | (trap_pend & ~trap_clr);
      per_pend   <= (per_pend | per_flag) & ~per_clr;
      take       <= grant;
      if (grant) vec_idx <= sel_vec;
      if (grant)         run_lvl <= sel_lvl;
      else if (lvl_load) run_lvl <= lvl_new;
    end
  end

  assign wake = reset_pend | tli_pend | trap_pend | (|ext_pend);

  // R1
  rst_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> take && vec_idx == VW'(VEC_RESET) && run_lvl == LVL_TOP);
  // R4
  lvl_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (take && vec_idx >= VW'(NMI_CNT)) |-> run_lvl > $past(run_lvl));
  // R5
  nmi_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (take && vec_idx < VW'(NMI_CNT)) |-> run_lvl == LVL_TOP);
  // R9
  take_src_chk: assert property (@(posedge clk) disable iff (rst)
    !(reset_pend || tli_pend || trap_pend || (|ext_pend) || (|per_pend)) |=> !take);
  // R10
  lvl_load_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_load |=> take || run_lvl == $past(lvl_new));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int N_EXT = 2, GRP_W = 2, N_PER = 4, N_SRC = 6, VW = 4;
  logic clk = 1'b0, rst = 1'b1, tli_pin = 1'b0, trap_req = 1'b0;
  logic [N_EXT*GRP_W-1:0] ext_pins = '1;
  logic [N_PER-1:0] per_flag = '0, per_clr = '0;
  logic [N_SRC-1:0] src_en = '0;
  logic [2*N_SRC-1:0] src_lvl = '0;
  logic lvl_load = 1'b0;
  logic [1:0] lvl_new = 2'd0;
  logic take, wake;
  logic [VW-1:0] vec_idx;
  logic [1:0] run_lvl;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_arbiter #(.N_EXT(N_EXT), .GRP_W(GRP_W), .N_PER(N_PER)) u0 (
    .clk(clk), .rst(rst), .tli_pin(tli_pin), .trap_req(trap_req),
    .ext_pins(ext_pins), .per_flag(per_flag), .per_clr(per_clr),
    .src_en(src_en), .src_lvl(src_lvl), .lvl_load(lvl_load), .lvl_new(lvl_new),
    .take(take), .vec_idx(vec_idx), .run_lvl(run_lvl), .wake(wake));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int i, input bit en, input int lvl);
    src_en[i] = en;
    src_lvl[2*i +: 2] = 2'(lvl);
  endtask

  task automatic load_lvl(input int l);
    @(negedge clk); lvl_load = 1'b1; lvl_new = 2'(l);
    @(negedge clk); lvl_load = 1'b0;
  endtask

  task automatic wait_take(input int maxc, output bit found, output int v, output int l);
    found = 1'b0; v = -1; l = -1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (take) begin found = 1'b1; v = vec_idx; l = run_lvl; return; end
    end
  endtask

  task automatic count_takes(input int n, output int cnt);
    cnt = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (take) cnt++;
    end
  endtask

  task automatic clear_per();
    @(negedge clk); per_clr = '1;
    @(negedge clk); per_clr = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(take == 1'b0, "R1 take in reset", take, 0);
    chk(run_lvl == 2'd3, "R1 level in reset", run_lvl, 3);
    rst = 1'b0;
    @(negedge clk);
    chk(take && vec_idx == 0 && run_lvl == 3, "R1 reset vector", vec_idx, 0);
    @(negedge clk);
    chk(take == 1'b0, "R9 single pulse", take, 0);
    load_lvl(0);
  endtask

  task automatic t_sw_level();
    bit f; int v, l;
    set_src(2, 1, 1); set_src(3, 1, 2);
    @(negedge clk); per_flag = 4'b0011;
    @(negedge clk); per_flag = '0;
    wait_take(6, f, v, l);
    chk(f && v == 6, "R2 higher level wins", v, 6);
    chk(l == 2, "R2 new level", l, 2);
    clear_per(); load_lvl(0);
  endtask

  task automatic t_hw_tie();
    bit f; int v, l;
    set_src(4, 1, 2); set_src(5, 1, 2);
    @(negedge clk); per_flag = 4'b1100;
    @(negedge clk); per_flag = '0;
    wait_take(6, f, v, l);
    chk(f && v == 7, "R3 lowest index wins tie", v, 7);
    clear_per(); load_lvl(0);
  endtask

  task automatic t_block();
    bit f; int v, l, cnt;
    set_src(2, 1, 2);
    load_lvl(2);
    @(negedge clk); per_flag = 4'b0001;
    @(negedge clk); per_flag = '0;
    count_takes(5, cnt);
    chk(cnt == 0, "R4 equal level held", cnt, 0);
    load_lvl(1);
    wait_take(6, f, v, l);
    chk(f && v == 5 && l == 2, "R4 taken after level drop", v, 5);
    clear_per(); load_lvl(0);
    set_src(3, 0, 3);
    @(negedge clk); per_flag = 4'b0010;
    @(negedge clk); per_flag = '0;
    count_takes(5, cnt);
    chk(cnt == 0, "R4 disabled held", cnt, 0);
    set_src(3, 1, 3);
    wait_take(6, f, v, l);
    chk(f && v == 6 && l == 3, "R4 taken after enable", v, 6);
    clear_per(); load_lvl(0);
  endtask

  task automatic t_nmi();
    bit f; int v, l, cnt;
    load_lvl(3);
    @(negedge clk); trap_req = 1'b1;
    @(negedge clk); trap_req = 1'b0;
    wait_take(6, f, v, l);
    chk(f && v == 2 && l == 3, "R5 trap at level 3", v, 2);
    @(negedge clk); tli_pin = 1'b1;
    wait_take(6, f, v, l);
    chk(f && v == 1 && l == 3, "R5 pin preempts trap", v, 1);
    count_takes(6, cnt);
    chk(cnt == 0, "R6 held pin one take", cnt, 0);
    @(negedge clk); tli_pin = 1'b0;
    @(negedge clk); tli_pin = 1'b1; trap_req = 1'b1;
    @(negedge clk); trap_req = 1'b0;
    wait_take(6, f, v, l);
    chk(f && v == 1, "R5 pin before trap", v, 1);
    wait_take(3, f, v, l);
    chk(f && v == 2, "R5 trap follows", v, 2);
    @(negedge clk); tli_pin = 1'b0;
    load_lvl(0);
  endtask

  task automatic t_nand();
    bit f; int v, l, cnt;
    set_src(0, 1, 1);
    @(negedge clk); ext_pins[0] = 1'b0;
    wait_take(6, f, v, l);
    chk(f && v == 3 && l == 1, "R7 group edge taken", v, 3);
    load_lvl(0);
    count_takes(4, cnt);
    chk(cnt == 0, "R7 latch cleared on take", cnt, 0);
    @(negedge clk); ext_pins[1] = 1'b0;
    count_takes(4, cnt);
    chk(cnt == 0, "R7 second pin no edge", cnt, 0);
    @(negedge clk); ext_pins[1:0] = 2'b11;
    @(negedge clk); ext_pins[1] = 1'b0;
    wait_take(6, f, v, l);
    chk(f && v == 3, "R7 new edge taken", v, 3);
    @(negedge clk); ext_pins[1:0] = 2'b11;
    load_lvl(0);
  endtask

  task automatic t_periph();
    bit f; int v, l, cnt;
    set_src(2, 1, 1);
    load_lvl(3);
    @(negedge clk); per_flag = 4'b0001;
    @(negedge clk); per_flag = '0;
    clear_per(); load_lvl(0);
    count_takes(5, cnt);
    chk(cnt == 0, "R8 cleared request lost", cnt, 0);
    @(negedge clk); per_flag = 4'b0001;
    @(negedge clk); per_flag = '0;
    wait_take(6, f, v, l);
    chk(f && v == 5, "R8 taken", v, 5);
    load_lvl(0);
    wait_take(4, f, v, l);
    chk(f && v == 5, "R8 take does not clear", v, 5);
    clear_per(); load_lvl(0);
  endtask

  task automatic t_load_race();
    set_src(2, 1, 2);
    @(negedge clk); per_flag = 4'b0001;
    @(negedge clk); per_flag = '0; lvl_load = 1'b1; lvl_new = 2'd1;
    @(negedge clk); lvl_load = 1'b0;
    chk(take && vec_idx == 5, "R9 take latency", vec_idx, 5);
    chk(run_lvl == 2, "R10 take overrides load", run_lvl, 2);
    clear_per(); load_lvl(0);
  endtask

  task automatic t_wake();
    bit f; int v, l, cnt;
    set_src(1, 0, 1);
    load_lvl(3);
    @(negedge clk); ext_pins[2] = 1'b0;
    @(negedge clk);
    chk(wake == 1'b1, "R11 wake on disabled line", wake, 1);
    count_takes(4, cnt);
    chk(cnt == 0, "R11 no take while masked", cnt, 0);
    set_src(1, 1, 1);
    load_lvl(0);
    wait_take(6, f, v, l);
    chk(f && v == 4, "R11 line taken later", v, 4);
    @(negedge clk);
    chk(wake == 1'b0, "R11 wake drops", wake, 0);
    ext_pins[2] = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sw_level();
    t_hw_tie();
    t_block();
    t_nmi();
    t_nand();
    t_periph();
    t_load_race();
    t_wake();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule